// File: doc/BRIEF.md
# Multiplexed IO Port Expander

This block provides seven general-purpose pins that software reaches through a small register window. Each pin has its own direction bit. The pins are also shared with three other functions. Pin 0 can carry a half-contrast switch input. Pin 1 can drive a sync output. Pins 6..2 can carry a five-bit colour bus input, where pin 2 holds colour bit 0 and pin 6 holds colour bit 4. A configuration register chooses which function owns each pin. The block computes the pad output values and output enables that follow from that choice.

Pin levels pass through a two-stage synchronizer before any internal use. The synchronized level is always readable. The block also derives an internal half-contrast signal from pin 0. That signal has its own force-high and polarity controls. The video-background copy of the signal is gated off while the RGB insertion path is active.

The register window has four addresses on `reg_addr`:

- 0 = port data (bits 6..0)
- 1 = direction (bits 6..0, 1 = output)
- 2 = configuration (bits 4..0)
- 3 = synchronized pin levels (read-only)

Configuration bits are: bit 0 `hc_sel` (pin 0 is the half-contrast input), bit 1 `sync_sel` (pin 1 is the sync output), bit 2 `color_en` (pins 6..2 are the colour bus), bit 3 `hc_force` and bit 4 `hc_pol`. Read data bits above the defined fields are zero.

Top module: `port_mux_expander`

## Requirements
- R1: While `rst_n` is low at a clock edge, data and direction clear to zero and configuration loads 0x04 (colour bus on, every other field off). As a result, pins 1..0 are inputs and `pad_oe` is zero.
- R2: A write (`reg_wr` high) to address 0, 1 or 2 takes effect at that clock edge. Reading the same address afterwards returns the written bits, with undefined bits read as zero. `reg_rdata` follows `reg_addr` without a clock delay.
- R3: Reading address 3 returns the value `pad_in` had two clock edges earlier. This holds whatever the direction or mode settings are.
- R4: A pin that no alternate function owns has `pad_oe` equal to its direction bit and `pad_out` equal to its data bit.
- R5: While `hc_sel` is 1, `pad_oe[0]` is 0 and writes to data bit 0 are ignored: bit 0 keeps its old value while bits 6..1 are written.
- R6: `hc_active` equals ((synchronized pin 0 AND `hc_sel`) OR `hc_force`) XOR `hc_pol`.
- R7: `video_half` equals `hc_active` while `rgb_insert` is 0, and is 0 while `rgb_insert` is 1.
- R8: While `sync_sel` is 1, `pad_oe[1]` is 1 and `pad_out[1]` follows `sync_in` with no clock delay, whatever the data and direction bits.
- R9: While `color_en` is 1, `pad_oe[6:2]` is 0 and `color_bus` equals synchronized pins 6..2. While `color_en` is 0, `color_bus` is 0 and pins 6..2 behave as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 data, 1 direction, 2 configuration, 3 pins) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| pad_in | input | 7 | Levels seen at the seven pins |
| pad_out | output | 7 | Values driven onto the pins |
| pad_oe | output | 7 | Output enable per pin |
| sync_in | input | 1 | Sync source for pin 1 |
| rgb_insert | input | 1 | High while the RGB insertion path is shown |
| color_bus | output | 5 | Colour bus to the core |
| hc_active | output | 1 | Internal half-contrast signal |
| video_half | output | 1 | Half-contrast request for the video background |

## Verification
Register writes appear on the readback and on the pad drive one clock edge after the strobe. Changes on `pad_in` reach the pin readback, `color_bus` and `hc_active` after exactly two edges. Changes on `sync_in`, `rgb_insert` and `reg_addr` reach the outputs in the same cycle. The bench drives its inputs 2 ns after each rising edge. A reference model updates at each rising edge, and all outputs are compared at the following falling edge. Because every latency is met by that falling edge, each result is compared in the cycle it is due and never before.

// File: rtl/pmx_pkg.sv
// Shared types for the multiplexed port expander.
// Assumes a 2-bit register address and a 5-bit configuration field.
package pmx_pkg;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_CFG  = 2'd2,
        ADDR_PIN  = 2'd3
    } pmx_addr_e;

    // Bit 0 hc_sel, bit 1 sync_sel, bit 2 color_en, bit 3 hc_force, bit 4 hc_pol
    typedef struct packed {
        logic hc_pol;
        logic hc_force;
        logic color_en;
        logic sync_sel;
        logic hc_sel;
    } pmx_cfg_t;

    localparam int CFG_W = $bits(pmx_cfg_t);
    localparam pmx_cfg_t CFG_RESET = '{hc_pol: 1'b0, hc_force: 1'b0, color_en: 1'b1,
                                       sync_sel: 1'b0, hc_sel: 1'b0};

endpackage

// File: rtl/pmx_sync.sv
// Multi-stage synchronizer for the pin levels.
// Assumes STAGES >= 1; every stage clears on reset.
module pmx_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the pin levels through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/pmx_regs.sv
// Register file: data, direction and configuration, plus the read mux.
// Assumes a single-cycle write strobe; read data is combinational.
module pmx_regs
    import pmx_pkg::*;
#(
    parameter int PORT_W = 7,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q,
    output pmx_cfg_t          cfg_q,
    output logic [REG_W-1:0]  rdata
);

    localparam int PAD_BITS = REG_W - PORT_W;
    localparam int CPAD     = REG_W - CFG_W;

    pmx_addr_e addr_e;
    assign addr_e = pmx_addr_e'(addr);

    // Data register; bit 0 is frozen while pin 0 serves the half-contrast input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr && addr_e == ADDR_DATA) begin
            data_q[PORT_W-1:1] <= wdata[PORT_W-1:1];
            if (!cfg_q.hc_sel) data_q[0] <= wdata[0];
        end
    end

    // Direction register, one bit per pin (1 = output)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr && addr_e == ADDR_DIR) begin
            dir_q <= wdata[PORT_W-1:0];
        end
    end

    // Configuration register selecting pin owners and half-contrast controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr && addr_e == ADDR_CFG) begin
            cfg_q <= pmx_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    // Readback multiplexer, undefined bits zero
    always_comb begin
        unique case (addr_e)
            ADDR_DATA: rdata = {{PAD_BITS{1'b0}}, data_q};
            ADDR_DIR:  rdata = {{PAD_BITS{1'b0}}, dir_q};
            ADDR_CFG:  rdata = {{CPAD{1'b0}}, cfg_q};
            default:   rdata = {{PAD_BITS{1'b0}}, pin_sync};
        endcase
    end

    a_r5_port0_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr_e == ADDR_DATA && cfg_q.hc_sel) |=> (data_q[0] == $past(data_q[0])));

    a_r2_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr_e == ADDR_DIR) |=> (dir_q == $past(wdata[PORT_W-1:0])));

endmodule

// File: rtl/pmx_pinmux.sv
// Pin ownership: pad drive and enables, colour bus, half-contrast derivation.
// Assumes pin 0 = half-contrast, pin 1 = sync, pins above 1 = colour bus.
module pmx_pinmux
    import pmx_pkg::*;
#(
    parameter int PORT_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORT_W-1:0]   data_q,
    input  logic [PORT_W-1:0]   dir_q,
    input  pmx_cfg_t            cfg_q,
    input  logic [PORT_W-1:0]   pin_sync,
    input  logic                sync_in,
    input  logic                rgb_insert,
    output logic [PORT_W-1:0]   pad_out,
    output logic [PORT_W-1:0]   pad_oe,
    output logic [PORT_W-3:0]   color_bus,
    output logic                hc_active,
    output logic                video_half
);

    localparam int COLOR_W = PORT_W - 2;

    // Pin 0: released as input while it serves the half-contrast switch
    always_comb begin
        pad_out[0] = data_q[0];
        pad_oe[0]  = dir_q[0] & ~cfg_q.hc_sel;
    end

    // Pin 1: sync source takes the pin and forces the driver on
    always_comb begin
        pad_out[1] = cfg_q.sync_sel ? sync_in : data_q[1];
        pad_oe[1]  = cfg_q.sync_sel | dir_q[1];
    end

    // Colour pins: each released to input while the colour bus owns it
    for (genvar g = 0; g < COLOR_W; g++) begin : g_color
        always_comb begin
            pad_out[g+2]  = data_q[g+2];
            pad_oe[g+2]   = dir_q[g+2] & ~cfg_q.color_en;
            color_bus[g]  = pin_sync[g+2] & cfg_q.color_en;
        end
    end

    // Half-contrast: gate, force, then polarity; background copy masked by RGB
    always_comb begin
        hc_active  = ((pin_sync[0] & cfg_q.hc_sel) | cfg_q.hc_force) ^ cfg_q.hc_pol;
        video_half = hc_active & ~rgb_insert;
    end

    a_r5_port0_released: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.hc_sel |-> !pad_oe[0]);

    a_r8_sync_owns_pin1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.sync_sel |-> (pad_oe[1] && pad_out[1] == sync_in));

    a_r9_color_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.color_en |-> (pad_oe[PORT_W-1:2] == '0));

    a_r9_color_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.color_en |-> (color_bus == '0));

    a_r7_rgb_full_contrast: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_insert |-> !video_half);

endmodule

// File: rtl/port_mux_expander.sv
// Top of the seven-pin multiplexed IO port expander.
// Assumes pad_in is asynchronous to clk; reset is synchronous active-low.
module port_mux_expander
    import pmx_pkg::*;
#(
    parameter int PORT_W      = 7,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    input  logic              sync_in,
    input  logic              rgb_insert,
    output logic [PORT_W-3:0] color_bus,
    output logic              hc_active,
    output logic              video_half
);

    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] dir_q;
    pmx_cfg_t          cfg_q;

    pmx_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_sync)
    );

    pmx_regs #(.PORT_W(PORT_W), .REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pin_sync(pin_sync),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .cfg_q   (cfg_q),
        .rdata   (reg_rdata)
    );

    pmx_pinmux #(.PORT_W(PORT_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .cfg_q     (cfg_q),
        .pin_sync  (pin_sync),
        .sync_in   (sync_in),
        .rgb_insert(rgb_insert),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .color_bus (color_bus),
        .hc_active (hc_active),
        .video_half(video_half)
    );

    // Cycles since reset, used to keep the latency check inside valid history
    logic [1:0] rst_age;
    always_ff @(posedge clk) begin
        if (!rst_n) rst_age <= '0;
        else if (rst_age != 2'd3) rst_age <= rst_age + 2'd1;
    end

    if (SYNC_STAGES == 2) begin : g_lat_chk
        a_r3_pin_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_age >= 2'd2) |-> (pin_sync == $past(pad_in, 2)));
    end

endmodule

// File: tb/port_mux_expander_tb.sv
module port_mux_expander_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [6:0] pad_in;
    logic [6:0] pad_out;
    logic [6:0] pad_oe;
    logic       sync_in;
    logic       rgb_insert;
    logic [4:0] color_bus;
    logic       hc_active;
    logic       video_half;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    port_mux_expander u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .sync_in(sync_in),
        .rgb_insert(rgb_insert), .color_bus(color_bus), .hc_active(hc_active),
        .video_half(video_half)
    );

    // Reference model state
    logic [6:0] m_data, m_dir;
    logic [4:0] m_cfg;
    logic [6:0] m_hist[$];
    bit         m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_dir = 0; m_cfg = 5'h04;
            m_hist = {7'h0, 7'h0};
            m_valid = 1;
        end else if (m_valid) begin
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_data = m_cfg[0] ? {reg_wdata[6:1], m_data[0]} : reg_wdata[6:0];
                    2'd1: m_dir  = reg_wdata[6:0];
                    2'd2: m_cfg  = reg_wdata[4:0];
                    default: ;
                endcase
            end
            m_hist.push_back(pad_in);
            void'(m_hist.pop_front());
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            logic [6:0] ps, eoe, eout;
            logic [4:0] ecol;
            logic       ehc;
            logic [7:0] erd;
            ps   = m_hist[0];
            eoe  = m_dir;
            eout = m_data;
            if (m_cfg[0]) eoe[0] = 1'b0;
            if (m_cfg[1]) begin eoe[1] = 1'b1; eout[1] = sync_in; end
            if (m_cfg[2]) eoe[6:2] = 5'b0;
            ecol = m_cfg[2] ? ps[6:2] : 5'b0;
            ehc  = ((ps[0] & m_cfg[0]) | m_cfg[3]) ^ m_cfg[4];
            case (reg_addr)
                2'd0: erd = {1'b0, m_data};
                2'd1: erd = {1'b0, m_dir};
                2'd2: erd = {3'b0, m_cfg};
                default: erd = {1'b0, ps};
            endcase
            chk("R4/R5/R8/R9", pad_oe, eoe, "pad_oe");
            chk("R4/R8", pad_out, eout, "pad_out");
            chk("R9", color_bus, ecol, "color_bus");
            chk("R6", hc_active, ehc, "hc_active");
            chk("R7", video_half, ehc & ~rgb_insert, "video_half");
            chk("R2/R3", reg_rdata, erd, "reg_rdata");
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic rd_at(logic [1:0] a, int exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp, "directed readback");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        pad_in = 0; sync_in = 0; rgb_insert = 0;
        repeat (3) step();
        // R1: reset values
        rd_at(2, 8'h04, "R1");
        rd_at(1, 8'h00, "R1");
        chk("R1", pad_oe, 0, "pad_oe after reset");
        rst_n = 1;
        step();
        // R4: pins 1..0 as outputs while colour bus keeps 6..2
        wr(1, 8'h7F);
        wr(0, 8'h55);
        chk("R9", pad_oe, 7'h03, "colour pins released");
        // R2: readback of each register; top bits dropped
        rd_at(0, 8'h55, "R2");
        wr(2, 8'hE0);
        rd_at(2, 8'h00, "R2");
        chk("R4", pad_oe, 7'h7F, "all pins GPIO output");
        chk("R4", pad_out, 7'h55, "GPIO drive");
        wr(0, 8'h2A);
        chk("R4", pad_out, 7'h2A, "GPIO drive new data");
        // R3: pin read latency with outputs enabled
        reg_addr = 3;
        pad_in = 7'h5A;
        step();
        chk("R3", reg_rdata, 0, "one edge: not yet visible");
        step();
        chk("R3", reg_rdata, 8'h5A, "two edges: visible");
        for (int i = 0; i < 8; i++) begin
            pad_in = 7'(i * 19 + 3);
            step();
        end
        // R9: colour bus follows pins while enabled
        wr(2, 8'h04);
        wr(1, 8'h00);
        for (int i = 0; i < 6; i++) begin
            pad_in = 7'(i * 37 + 11);
            step(); step();
            chk("R9", color_bus, int'(pad_in[6:2]), "colour bus value");
        end
        // R5: half-contrast takes pin 0; data bit 0 frozen
        wr(1, 8'h01);
        wr(0, 8'h01);
        wr(2, 8'h01);
        chk("R5", pad_oe[0], 0, "pin0 driver off");
        wr(0, 8'h7E);
        rd_at(0, 8'h7F, "R5");
        wr(0, 8'h00);
        rd_at(0, 8'h01, "R5");
        // R6/R7: enable, force and polarity combinations
        for (int c = 0; c < 8; c++) begin
            wr(2, 8'(((c & 6) << 2) | 1));
            for (int p = 0; p < 2; p++) begin
                pad_in = 7'(p);
                rgb_insert = 1'(c & 1);
                step(); step();
                chk("R6", hc_active, (((p & 1) | ((c >> 1) & 1)) ^ ((c >> 2) & 1)), "hc combo");
                rgb_insert = ~rgb_insert;
                #1;
                chk("R7", video_half, int'(hc_active & ~rgb_insert), "rgb gate");
            end
        end
        wr(2, 8'h00);
        pad_in = 7'h01;
        step(); step();
        chk("R6", hc_active, 0, "pin ignored when not selected");
        // R8: sync output owns pin 1 whatever direction/data say
        wr(1, 8'h00);
        wr(0, 8'h02);
        wr(2, 8'h02);
        for (int i = 0; i < 4; i++) begin
            sync_in = 1'(i);
            #1;
            chk("R8", {pad_oe[1], pad_out[1]}, {1'b1, 1'(i)}, "sync drive");
            step();
        end
        wr(2, 8'h00);
        chk("R4", pad_oe[1], 0, "pin1 back to GPIO input");
        repeat (3) step();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule